// File: doc/BRIEF.md
# Event-Driven Reload Down-Counter

This block is a down-counter whose count steps come from edges on an external event line. Software programs a start value through a small register port, then starts the counter with a trigger bit or by turning the count enable on. Each rising edge of the event line takes one off the count. When the count passes from zero to all ones, the block raises a sticky underflow flag. The flag can be masked into an interrupt line.

Two run modes are available. In continuous mode the counter refills from the start value at each wrap, and the timer output toggles there, so it carries a square wave. In single-shot mode the counter parks at all ones after the wrap and ignores further events until it is started again. In this mode the timer output is high only while a run is in progress.

The register port has three words, chosen by `reg_addr`. Word 0 is control and status: bit 0 is count enable, bit 1 is the start trigger, bit 2 is mode (1 = continuous, 0 = single-shot), bit 3 is interrupt enable, and bit 4 is the underflow flag. Word 1 holds the start value. Word 2 returns the live count and cannot be written. A write takes effect at the clock edge where `reg_wr` is high, and reads are combinational.

Top module: `evt_down_timer`

## Requirements
- R1: After reset the count word reads 0xFFFF, the control word reads 0, and `tmr_out` and `irq` are 0.
- R2: A control write with bit 1 set copies the start value into the counter at that edge and starts a run. Bit 1 always reads back as 0.
- R3: A control write that changes bit 0 from 0 to 1 also copies the start value into the counter and starts a run.
- R4: `evt_in` passes through two synchronizing flip-flops. Each rising edge seen after them takes exactly one off the count while the block is enabled and a run is in progress.
- R5: While bit 0 is 0, event edges leave the count unchanged.
- R6: In continuous mode, an event at count 0 reloads the start value and sets the underflow flag.
- R7: In single-shot mode, an event at count 0 leaves the count at 0xFFFF and sets the underflow flag. Later events change nothing until a new start.
- R8: The underflow flag (bit 4) stays set until a control write carries 0 in bit 4. Writing 1 there has no effect. If an underflow and a clearing write hit the same edge, the flag ends up set.
- R9: `irq` is 1 exactly when the underflow flag and the interrupt enable bit (bit 3) are both 1.
- R10: In single-shot mode, `tmr_out` is 1 from a start until the underflow, or until bit 0 is cleared.
- R11: In continuous mode, a start drives `tmr_out` to 0, and each underflow inverts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected word |
| evt_in | input | 1 | Asynchronous event input |
| tmr_out | output | 1 | Timer output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clearing write to the underflow flag that lands on the same edge as the underflow itself. The event input goes through a two-flop synchronizer and an edge detector, so the decrement happens at the third rising clock edge after the input changes. The bench parks the counter at zero in continuous mode and raises `evt_in` just before a known edge. It then places the clearing write exactly on the third edge, which shows whether setting the flag takes priority over clearing it.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 2;

    // control word bit positions
    localparam int CB_EN   = 0;
    localparam int CB_TRIG = 1;
    localparam int CB_MODE = 2;
    localparam int CB_IE   = 3;
    localparam int CB_UF   = 4;
    localparam int CB_TOP  = CB_UF;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_START  = 2'd1,
        REG_COUNT  = 2'd2,
        REG_UNUSED = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_CONT   = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic      en;
        run_mode_e mode;
        logic      ie;
    } ctrl_t;

    function automatic logic is_ctrl_write(input logic wr, input logic [ADDR_W-1:0] a);
        return wr && (a == REG_CTRL);
    endfunction

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic strobe
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign strobe = chain[STAGES-1] & ~prev;

    // R4: one edge yields a single-cycle strobe
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

endmodule

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
    import evt_timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              underflow,
    input  logic [W-1:0]      count_val,
    output ctrl_t             ctrl,
    output logic [W-1:0]      start_val,
    output logic              load,
    output logic              uf,
    output logic              irq,
    output logic [W-1:0]      rdata
);
    logic ctl_wr;
    logic uf_clr;

    assign ctl_wr = is_ctrl_write(wr, addr);
    assign load   = ctl_wr && (wdata[CB_TRIG] || (wdata[CB_EN] && !ctrl.en));
    assign uf_clr = ctl_wr && !wdata[CB_UF];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '{en: 1'b0, mode: MODE_SINGLE, ie: 1'b0};
            start_val <= '0;
            uf        <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctrl.en   <= wdata[CB_EN];
                ctrl.mode <= run_mode_e'(wdata[CB_MODE]);
                ctrl.ie   <= wdata[CB_IE];
            end
            if (wr && addr == REG_START)
                start_val <= wdata;
            if (underflow)
                uf <= 1'b1;
            else if (uf_clr)
                uf <= 1'b0;
        end
    end

    assign irq = uf & ctrl.ie;

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            REG_CTRL: begin
                rdata[CB_EN]   = ctrl.en;
                rdata[CB_MODE] = ctrl.mode;
                rdata[CB_IE]   = ctrl.ie;
                rdata[CB_UF]   = uf;
            end
            REG_START: rdata = start_val;
            REG_COUNT: rdata = count_val;
            default:   rdata = '0;
        endcase
    end

    // R8: an underflow always leaves the flag set, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        underflow |=> uf);
    // R8: the flag only drops through a clearing write
    a_r8_uf_sticky: assert property (@(posedge clk) disable iff (rst)
        (uf && !uf_clr) |=> uf);

endmodule

// File: rtl/evt_down_count.sv
module evt_down_count
    import evt_timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] start_val,
    input  logic         load,
    input  logic         strobe,
    output logic [W-1:0] count,
    output logic         underflow,
    output logic         running,
    output logic         tout
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic step;
    logic at_zero;
    logic tgl;

    assign step      = ctrl.en && running && strobe && !load;
    assign at_zero   = (count == '0);
    assign underflow = step && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= ALL_ONES;
            running <= 1'b0;
            tgl     <= 1'b0;
        end else if (load) begin
            count   <= start_val;
            running <= 1'b1;
            tgl     <= 1'b0;
        end else if (step) begin
            if (!at_zero) begin
                count <= count - 1'b1;
            end else if (ctrl.mode == MODE_CONT) begin
                count <= start_val;
                tgl   <= ~tgl;
            end else begin
                count   <= ALL_ONES;
                running <= 1'b0;
            end
        end
    end

    assign tout = (ctrl.mode == MODE_SINGLE) ? (running & ctrl.en) : tgl;

    // R2/R3: a start copies the start value
    a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(start_val));
    // R5: disabled counter holds its value
    a_r5_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !load) |=> $stable(count));
    // R7: a finished single-shot run stays parked
    a_r7_halted_hold: assert property (@(posedge clk) disable iff (rst)
        (!running && !load) |=> $stable(count));
    // R6: continuous mode refills on wrap
    a_r6_refill: assert property (@(posedge clk) disable iff (rst)
        (underflow && ctrl.mode == MODE_CONT) |=> count == $past(start_val));

endmodule

// File: rtl/evt_down_timer.sv
module evt_down_timer
    import evt_timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              evt_in,
    output logic              tmr_out,
    output logic              irq
);
    ctrl_t        ctrl;
    logic [W-1:0] start_val;
    logic [W-1:0] count;
    logic         load;
    logic         uf;
    logic         underflow;
    logic         strobe;
    logic         running;

    evt_edge_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (evt_in),
        .strobe   (strobe)
    );

    evt_ctrl_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .underflow (underflow),
        .count_val (count),
        .ctrl      (ctrl),
        .start_val (start_val),
        .load      (load),
        .uf        (uf),
        .irq       (irq),
        .rdata     (reg_rdata)
    );

    evt_down_count #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .start_val (start_val),
        .load      (load),
        .strobe    (strobe),
        .count     (count),
        .underflow (underflow),
        .running   (running),
        .tout      (tmr_out)
    );

    // R9: no interrupt without the flag
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> uf);

endmodule

// File: tb/test_evt_down_timer.sv
module test_evt_down_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        evt_in = 1'b0;
    logic        tmr_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_down_timer i_evt_down_timer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .tmr_out(tmr_out), .irq(irq)
    );

    function automatic logic [15:0] cw(input bit en, input bit trig, input bit cont,
                                       input bit ie, input bit uf);
        return {11'd0, uf, ie, cont, trig, en};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse();
        @(negedge clk); evt_in = 1'b1;
        repeat (3) @(negedge clk);
        evt_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(2'd2, d); check("R1 count", d, 16'hFFFF);
        rd(2'd0, d); check("R1 ctrl", d, 16'h0000);
        check("R1 tout", {15'd0, tmr_out}, 16'd0);
        check("R1 irq", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_trigger();
        logic [15:0] d;
        wr(2'd1, 16'd5);
        wr(2'd0, cw(0, 1, 0, 0, 1));
        rd(2'd2, d); check("R2 load", d, 16'd5);
        rd(2'd0, d); check("R2 trig reads 0", d & 16'h0002, 16'd0);
    endtask

    task automatic t_enable_load();
        logic [15:0] d;
        wr(2'd1, 16'd7);
        wr(2'd0, cw(1, 0, 0, 0, 1));
        rd(2'd2, d); check("R3 enable loads", d, 16'd7);
        check("R10 tout high while running", {15'd0, tmr_out}, 16'd1);
        repeat (3) pulse();
        rd(2'd2, d); check("R4 three events", d, 16'd4);
    endtask

    task automatic t_disable();
        logic [15:0] d;
        wr(2'd0, cw(0, 0, 0, 0, 1));
        check("R10 tout low when disabled", {15'd0, tmr_out}, 16'd0);
        repeat (2) pulse();
        rd(2'd2, d); check("R5 frozen", d, 16'd4);
    endtask

    task automatic t_single_shot();
        logic [15:0] d;
        wr(2'd1, 16'd1);
        wr(2'd0, cw(1, 1, 0, 0, 1));
        pulse();
        rd(2'd2, d); check("R4 one step", d, 16'd0);
        check("R10 still high at 0", {15'd0, tmr_out}, 16'd1);
        pulse();
        rd(2'd2, d); check("R7 parks", d, 16'hFFFF);
        rd(2'd0, d); check("R7 flag set", d & 16'h0010, 16'h0010);
        check("R10 low after wrap", {15'd0, tmr_out}, 16'd0);
        check("R9 masked", {15'd0, irq}, 16'd0);
        pulse();
        rd(2'd2, d); check("R7 ignores events", d, 16'hFFFF);
        wr(2'd0, cw(1, 0, 0, 1, 1));
        rd(2'd0, d); check("R8 writing 1 keeps flag", d & 16'h0010, 16'h0010);
        check("R9 irq", {15'd0, irq}, 16'd1);
        wr(2'd0, cw(1, 0, 0, 1, 0));
        rd(2'd0, d); check("R8 cleared", d & 16'h0010, 16'd0);
        check("R9 irq drops", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_continuous();
        logic [15:0] d;
        wr(2'd1, 16'd2);
        wr(2'd0, cw(1, 1, 1, 0, 0));
        check("R11 start low", {15'd0, tmr_out}, 16'd0);
        repeat (3) pulse();
        rd(2'd2, d); check("R6 refill", d, 16'd2);
        rd(2'd0, d); check("R6 flag", d & 16'h0010, 16'h0010);
        check("R11 toggled", {15'd0, tmr_out}, 16'd1);
        repeat (3) pulse();
        rd(2'd2, d); check("R6 refill again", d, 16'd2);
        check("R11 toggled back", {15'd0, tmr_out}, 16'd0);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        repeat (2) pulse();
        wr(2'd0, cw(1, 0, 1, 0, 0));
        rd(2'd2, d); check("R8 setup at 0", d, 16'd0);
        rd(2'd0, d); check("R8 setup clear", d & 16'h0010, 16'd0);
        @(negedge clk); evt_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = cw(1, 0, 1, 0, 0);
        @(negedge clk);
        reg_wr = 1'b0; evt_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd0, d); check("R8 set beats clear", d & 16'h0010, 16'h0010);
        rd(2'd2, d); check("R6 refill on contested edge", d, 16'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_trigger();
        t_enable_load();
        t_disable();
        t_single_shot();
        t_continuous();
        t_set_wins();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule